// File: doc/BRIEF.md
# BCD Clock Calendar Time Counter

This block keeps time of day and date for a low-power clock. It is fed by a system clock plus an enable that pulses once per period of a 32.768 kHz time base. A binary prescaler divides those enable ticks. Its outputs are a 128 Hz trimming square wave and a 1 Hz square wave. A small seconds stage turns the falling edges of the 1 Hz wave into a square wave with one period per minute. Each falling edge of that minute wave advances a packed-BCD calendar of minutes, hours, days and months.

The calendar uses fixed month lengths and has no leap-year logic. February wraps after day 28. The one exception is a day value of 29 written by the host, which wraps to 01 on the next day step. A host write port can load any single field at any time. The prescaler keeps running across such writes. The calendar step is a small state machine with four states:

- `CAL_IDLE` waits for the minute tick and steps the minute field. On a minute wrap it moves to `CAL_HOUR`; otherwise it stays.
- `CAL_HOUR` steps the hour. On an hour wrap it moves to `CAL_DAY`; otherwise it returns to `CAL_IDLE`.
- `CAL_DAY` steps the day. On a day wrap it moves to `CAL_MONTH`; otherwise it returns to `CAL_IDLE`.
- `CAL_MONTH` steps the month and always returns to `CAL_IDLE`.

A host write to the field being stepped in a given state cancels the carry out of that state.

Top module: `rtc_time_counter`

## Requirements
- R1: `trim_out` is a square wave with equal high and low times of 2^TRIM_BIT enabled ticks each. With the defaults this is 128 Hz from a 32.768 kHz enable.
- R2: `sec_out` is a square wave with equal high and low times of 2^(PRESC_W-1) enabled ticks each. With the defaults this is 1 Hz. It is low for the first half of each period after reset.
- R3: `min_out` changes state only on a falling edge of `sec_out`, once every HALF_MIN_SECS such edges. It is therefore high and low for equal times.
- R4: Minutes count in BCD from 00 to 59. The minute field steps on the same clock edge on which `min_out` falls. From 59 (or any higher loaded value) it wraps to 00 and carries into hours.
- R5: Hours count in BCD from 00 to 23. From 23 they wrap to 00 and carry into days.
- R6: Days step in BCD. They wrap to 01 and carry into months after day 31 in months 01, 03, 05, 07, 08, 10 and 12, and after day 30 in months 04, 06, 09 and 11.
- R7: In month 02, day 28 steps to 01 and carries. A loaded day 29 also steps to 01 and carries.
- R8: Months count in BCD from 01 to 12. From 12 they wrap to 01.
- R9: `time_word` packs month in [23:19], day in [18:13], hour in [12:7] and minute in [6:0], each in BCD.
- R10: When `wr_en` is high, `wr_data` is loaded into the field named by `wr_sel` on the next edge. The encoding is 0 = minute, 1 = hour, 2 = day, 3 = month. The write wins over a step of the same field in that cycle and suppresses that step's carry. The write does not disturb the prescaler.
- R11: Synchronous active-low reset sets `time_word` to 24'h082000 (month 01, day 01, 00:00) and drives `trim_out`, `sec_out` and `min_out` low.
- R12: While `osc_en` is low, the prescaler, the square waves and the time hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_en | input | 1 | One-cycle enable per time-base tick |
| wr_en | input | 1 | Host field write strobe |
| wr_sel | input | 2 | Field select: 0 minute, 1 hour, 2 day, 3 month |
| wr_data | input | 8 | BCD value to load (truncated to field width) |
| trim_out | output | 1 | Oscillator trimming square wave |
| sec_out | output | 1 | Seconds square wave |
| min_out | output | 1 | Minutes square wave |
| time_word | output | 24 | Packed BCD month, day, hour, minute |

## Verification
The bench loads times that sit on every wrap boundary. These include minute 59 with hour 23, the last day of a 30-day month, a 31-day month, February 28, a loaded February 29 and December 31. It also covers a BCD digit carry such as 09 to 10. A design with a wrong month-length table would roll over a day early or late, or jump into day 32. A design that dropped the carry chain would leave the hour or the month unchanged. One test times a minute write so it lands on the very edge of a minute step. A design without write priority would let the step or its carry into the hour corrupt the loaded value. The bench also measures the high and low times of each square wave and checks that a low enable freezes everything.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int MIN_W  = 7;
    localparam int HOUR_W = 6;
    localparam int DAY_W  = 6;
    localparam int MON_W  = 5;
    localparam int TIME_W = MIN_W + HOUR_W + DAY_W + MON_W;

    typedef enum logic [1:0] {
        FLD_MIN   = 2'd0,
        FLD_HOUR  = 2'd1,
        FLD_DAY   = 2'd2,
        FLD_MONTH = 2'd3
    } fld_e;

    typedef enum logic [1:0] {
        CAL_IDLE  = 2'd0,
        CAL_HOUR  = 2'd1,
        CAL_DAY   = 2'd2,
        CAL_MONTH = 2'd3
    } cal_state_e;

    // one-step BCD increment of a two-digit value
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        logic [7:0] r;
        if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
        else                r = v + 8'd1;
        return r;
    endfunction

    // last day of a BCD month with a fixed 28-day February
    function automatic logic [DAY_W-1:0] last_day(input logic [MON_W-1:0] mo);
        logic [DAY_W-1:0] d;
        case (mo)
            5'h02:                      d = 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: d = 6'h30;
            default:                    d = 6'h31;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int PRESC_W  = 15,
    parameter int TRIM_BIT = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_en,
    output logic trim_out,
    output logic sec_out,
    output logic sec_fall
);

    logic [PRESC_W-1:0] div_q;

    always_ff @(posedge clk) begin
        if (!rst_n)      div_q <= '0;
        else if (osc_en) div_q <= div_q + 1'b1;
    end

    assign trim_out = div_q[TRIM_BIT];
    assign sec_out  = div_q[PRESC_W-1];
    // the top bit drops when the all-ones value rolls over
    assign sec_fall = osc_en && (&div_q);

    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |=> ($stable(trim_out) && $stable(sec_out)));

    p_sec_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sec_fall |=> !sec_out);

endmodule

// File: rtl/rtc_minute_wave.sv
module rtc_minute_wave #(
    parameter int HALF_MIN_SECS = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sec_out,
    input  logic sec_fall,
    output logic min_out,
    output logic min_tick
);

    localparam int SC_W = (HALF_MIN_SECS > 2) ? $clog2(HALF_MIN_SECS) : 1;
    localparam logic [SC_W-1:0] SC_LAST = SC_W'(HALF_MIN_SECS - 1);

    logic [SC_W-1:0] sc_q;
    logic            min_q;
    logic            half_done;

    assign half_done = sec_fall && (sc_q == SC_LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sc_q  <= '0;
            min_q <= 1'b0;
        end else begin
            if (half_done)     sc_q <= '0;
            else if (sec_fall) sc_q <= sc_q + 1'b1;
            if (half_done)     min_q <= ~min_q;
        end
    end

    assign min_out  = min_q;
    // falling edge of the minute wave advances the calendar
    assign min_tick = half_done && min_q;

    p_min_on_sec_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (min_out != $past(min_out)) |-> ($past(sec_out) && !sec_out));

    p_tick_on_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        min_tick |=> !min_out);

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              min_tick,
    input  logic              wr_en,
    input  fld_e              wr_sel,
    input  logic [7:0]        wr_data,
    output logic [TIME_W-1:0] time_word
);

    cal_state_e state_q, state_nx;

    logic [MIN_W-1:0]  min_q,  min_nx;
    logic [HOUR_W-1:0] hr_q,   hr_nx;
    logic [DAY_W-1:0]  day_q,  day_nx;
    logic [MON_W-1:0]  mon_q,  mon_nx;

    logic hit_min, hit_hr, hit_day, hit_mon;
    logic step_min, step_hr, step_day, step_mon;
    logic wrap_min, wrap_hr, wrap_day, wrap_mon;

    assign hit_min = wr_en && (wr_sel == FLD_MIN);
    assign hit_hr  = wr_en && (wr_sel == FLD_HOUR);
    assign hit_day = wr_en && (wr_sel == FLD_DAY);
    assign hit_mon = wr_en && (wr_sel == FLD_MONTH);

    assign wrap_min = (min_q >= 7'h59);
    assign wrap_hr  = (hr_q  >= 6'h23);
    assign wrap_day = (day_q >= last_day(mon_q));
    assign wrap_mon = (mon_q >= 5'h12);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CAL_IDLE;
        else        state_q <= state_nx;
    end

    // step enables and next state
    always_comb begin
        state_nx = CAL_IDLE;
        step_min = 1'b0;
        step_hr  = 1'b0;
        step_day = 1'b0;
        step_mon = 1'b0;
        unique case (state_q)
            CAL_IDLE: begin
                if (min_tick) begin
                    step_min = 1'b1;
                    if (wrap_min && !hit_min) state_nx = CAL_HOUR;
                end
            end
            CAL_HOUR: begin
                step_hr = 1'b1;
                if (wrap_hr && !hit_hr) state_nx = CAL_DAY;
            end
            CAL_DAY: begin
                step_day = 1'b1;
                if (wrap_day && !hit_day) state_nx = CAL_MONTH;
            end
            CAL_MONTH: begin
                step_mon = 1'b1;
            end
            default: state_nx = CAL_IDLE;
        endcase
    end

    // field next values: host write first, then the step
    always_comb begin
        min_nx = min_q;
        hr_nx  = hr_q;
        day_nx = day_q;
        mon_nx = mon_q;

        if (hit_min)       min_nx = wr_data[MIN_W-1:0];
        else if (step_min) min_nx = wrap_min ? '0 : MIN_W'(bcd_inc({1'b0, min_q}));

        if (hit_hr)        hr_nx = wr_data[HOUR_W-1:0];
        else if (step_hr)  hr_nx = wrap_hr ? '0 : HOUR_W'(bcd_inc({2'b0, hr_q}));

        if (hit_day)       day_nx = wr_data[DAY_W-1:0];
        else if (step_day) day_nx = wrap_day ? DAY_W'(1) : DAY_W'(bcd_inc({2'b0, day_q}));

        if (hit_mon)       mon_nx = wr_data[MON_W-1:0];
        else if (step_mon) mon_nx = wrap_mon ? MON_W'(1) : MON_W'(bcd_inc({3'b0, mon_q}));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            min_q <= '0;
            hr_q  <= '0;
            day_q <= DAY_W'(1);
            mon_q <= MON_W'(1);
        end else begin
            min_q <= min_nx;
            hr_q  <= hr_nx;
            day_q <= day_nx;
            mon_q <= mon_nx;
        end
    end

    assign time_word = {mon_q, day_q, hr_q, min_q};

    p_tick_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        min_tick |-> (state_q == CAL_IDLE));

    p_min_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (min_tick && min_q == 7'h59 && !hit_min) |=> (min_q == '0 && state_q == CAL_HOUR));

    p_hr_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CAL_HOUR && hr_q == 6'h23 && !hit_hr) |=> (hr_q == '0));

    p_feb_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CAL_DAY && mon_q == 5'h02 && (day_q == 6'h28 || day_q == 6'h29) && !hit_day)
        |=> (day_q == 6'h01 && state_q == CAL_MONTH));

    p_mon_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CAL_MONTH && mon_q == 5'h12 && !hit_mon) |=> (mon_q == 5'h01));

    p_write_min_r10: assert property (@(posedge clk) disable iff (!rst_n)
        hit_min |=> (min_q == $past(wr_data[MIN_W-1:0])));

    p_write_day_r10: assert property (@(posedge clk) disable iff (!rst_n)
        hit_day |=> (day_q == $past(wr_data[DAY_W-1:0])));

endmodule

// File: rtl/rtc_time_counter.sv
module rtc_time_counter #(
    parameter int PRESC_W       = 15,
    parameter int TRIM_BIT      = 7,
    parameter int HALF_MIN_SECS = 30
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        osc_en,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  logic [7:0]  wr_data,
    output logic        trim_out,
    output logic        sec_out,
    output logic        min_out,
    output logic [23:0] time_word
);

    import rtc_pkg::*;

    logic sec_fall;
    logic min_tick;
    fld_e sel_fld;

    assign sel_fld = fld_e'(wr_sel);

    rtc_prescaler #(
        .PRESC_W  (PRESC_W),
        .TRIM_BIT (TRIM_BIT)
    ) u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .osc_en   (osc_en),
        .trim_out (trim_out),
        .sec_out  (sec_out),
        .sec_fall (sec_fall)
    );

    rtc_minute_wave #(
        .HALF_MIN_SECS (HALF_MIN_SECS)
    ) u_minw (
        .clk      (clk),
        .rst_n    (rst_n),
        .sec_out  (sec_out),
        .sec_fall (sec_fall),
        .min_out  (min_out),
        .min_tick (min_tick)
    );

    rtc_calendar u_cal (
        .clk       (clk),
        .rst_n     (rst_n),
        .min_tick  (min_tick),
        .wr_en     (wr_en),
        .wr_sel    (sel_fld),
        .wr_data   (wr_data),
        .time_word (time_word)
    );

    p_reset_word_r11: assert property (@(posedge clk)
        !rst_n |=> (time_word == 24'h082000 && !sec_out && !min_out && !trim_out));

endmodule

// File: tb/sim_rtc_time_counter.sv
`timescale 1ns/1ps
module sim_rtc_time_counter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        osc_en = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [7:0]  wr_data = 8'd0;
    logic        trim_out, sec_out, min_out;
    logic [23:0] time_word;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    rtc_time_counter #(.PRESC_W(4), .TRIM_BIT(1), .HALF_MIN_SECS(2)) u0 (
        .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .trim_out(trim_out),
        .sec_out(sec_out), .min_out(min_out), .time_word(time_word)
    );

    // {start word, expected word after one minute step}; word = {mo5, da6, hr6, mi7} (R9)
    localparam logic [47:0] VEC [14] = '{
        {5'h03,6'h15,6'h10,7'h22, 5'h03,6'h15,6'h10,7'h23},
        {5'h03,6'h15,6'h10,7'h59, 5'h03,6'h15,6'h11,7'h00},
        {5'h03,6'h15,6'h23,7'h59, 5'h03,6'h16,6'h00,7'h00},
        {5'h01,6'h31,6'h23,7'h59, 5'h02,6'h01,6'h00,7'h00},
        {5'h04,6'h30,6'h23,7'h59, 5'h05,6'h01,6'h00,7'h00},
        {5'h04,6'h29,6'h23,7'h59, 5'h04,6'h30,6'h00,7'h00},
        {5'h02,6'h28,6'h23,7'h59, 5'h03,6'h01,6'h00,7'h00},
        {5'h02,6'h29,6'h23,7'h59, 5'h03,6'h01,6'h00,7'h00},
        {5'h02,6'h27,6'h23,7'h59, 5'h02,6'h28,6'h00,7'h00},
        {5'h12,6'h31,6'h23,7'h59, 5'h01,6'h01,6'h00,7'h00},
        {5'h09,6'h30,6'h23,7'h59, 5'h10,6'h01,6'h00,7'h00},
        {5'h11,6'h30,6'h23,7'h59, 5'h12,6'h01,6'h00,7'h00},
        {5'h08,6'h31,6'h23,7'h59, 5'h09,6'h01,6'h00,7'h00},
        {5'h06,6'h29,6'h12,7'h09, 5'h06,6'h29,6'h12,7'h10}
    };

    localparam string VEC_REQ [14] = '{"R4","R5","R5","R6","R6","R6","R7",
                                       "R7","R7","R8","R6","R8","R6","R4"};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load_word(input logic [23:0] w);
        put(2'd3, {3'b0, w[23:19]});
        put(2'd2, {2'b0, w[18:13]});
        put(2'd1, {2'b0, w[12:7]});
        put(2'd0, {1'b0, w[6:0]});
    endtask

    function automatic logic pick(input int which);
        if (which == 0)      return trim_out;
        else if (which == 1) return sec_out;
        else                 return min_out;
    endfunction

    task automatic wait_level(input int which, input logic lvl);
        do @(negedge clk); while (pick(which) !== lvl);
    endtask

    task automatic measure(input int which, output int hi, output int lo);
        wait_level(which, 1'b0);
        wait_level(which, 1'b1);
        hi = 0;
        while (pick(which) === 1'b1) begin @(negedge clk); hi++; end
        lo = 0;
        while (pick(which) === 1'b0) begin @(negedge clk); lo++; end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R1..: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int hi, lo;
        logic [23:0] held;
        logic [2:0]  waves;

        // R11 reset state
        repeat (3) @(negedge clk);
        chk("R11", {5'b0, trim_out, sec_out, min_out, time_word}, {8'b0, 24'h082000});
        rst_n = 1'b1;

        // R1, R2, R3 square-wave timing
        measure(0, hi, lo);
        chk("R1 trim high", hi, 2);
        chk("R1 trim low", lo, 2);
        measure(1, hi, lo);
        chk("R2 sec high", hi, 8);
        chk("R2 sec low", lo, 8);
        measure(2, hi, lo);
        chk("R3 min high", hi, 32);
        chk("R3 min low", lo, 32);

        // table of wrap and carry vectors (R4..R9)
        for (int i = 0; i < 14; i++) begin
            wait_level(2, 1'b1);
            load_word(VEC[i][47:24]);
            chk({VEC_REQ[i], " load R10"}, time_word, VEC[i][47:24]);
            wait_level(2, 1'b0);
            repeat (8) @(negedge clk);
            chk({VEC_REQ[i], " step R9"}, time_word, VEC[i][23:0]);
        end

        // R10 write lands on the minute step edge: write wins, no hour carry
        wait_level(2, 1'b0);
        load_word({5'h05, 6'h05, 6'h10, 7'h59});
        wait_level(2, 1'b1);
        repeat (31) @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'd0; wr_data = 8'h30;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R10 edge fell", {31'b0, min_out}, 32'd0);
        repeat (8) @(negedge clk);
        chk("R10 collide", time_word, {5'h05, 6'h05, 6'h10, 7'h30});

        // R12 enable low freezes everything
        @(negedge clk);
        osc_en = 1'b0;
        @(negedge clk);
        held  = time_word;
        waves = {trim_out, sec_out, min_out};
        repeat (100) @(negedge clk);
        chk("R12 time", time_word, held);
        chk("R12 waves", {29'b0, trim_out, sec_out, min_out}, {29'b0, waves});
        osc_en = 1'b1;

        // R11 reset in mid run
        load_word({5'h07, 6'h22, 6'h13, 7'h45});
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R11 rerun", {5'b0, trim_out, sec_out, min_out, time_word}, {8'b0, 24'h082000});
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        finish_run();
    end

endmodule